// File: doc/BRIEF.md
# Address Window Bridge Translator

This block sits between a processor-side bus and a child bus that has four address spaces: memory, I/O, configuration and special. A configuration port loads at most one window per child space, each made of a parent base, a child base and a byte size. Every outbound request from the parent side carries an address, a byte count and a direction. The block looks for a window that holds the whole access. On a hit it forwards the request with a translated child address and the index of the matching space. On a miss it reports a completion with zero bytes moved.

A second path carries DMA from the child side towards the parent. DMA is only legal in the memory space. The block refuses any DMA whose first or last byte address lands inside the bridge's own child memory window. Legal DMA goes upward, tagged with the parent space recorded for the memory window. All results appear one clock after the request, as single-cycle pulses. The window table is cleared by reset and by a re-initialise strobe.

Top module: `addr_window_bridge`

## Requirements
- R1: Space indices are memory=0, I/O=1, configuration=2, special=3, carried on a 3-bit `cfg_space`. A configuration write to an index 0..3 whose window has size zero stores the parent base, child base, size and parent-space tag.
- R2: A configuration write to an index whose stored size is nonzero pulses `cfg_err_dup` for one cycle, one clock later. The stored window is left unchanged.
- R3: A configuration write with `cfg_space` 4..7 pulses `cfg_err_space` for one cycle, one clock later, and changes no window.
- R4: A window of nonzero size matches a request when addr >= parent base and addr + count <= parent base + size. Both sums are evaluated one bit wider than the address, so they never wrap.
- R5: One clock after a matching request, `fwd_valid` pulses for one cycle. It carries `fwd_addr` = addr - parent base + child base, the space index in `fwd_space`, and the count and direction unchanged.
- R6: Every request pulses `done_valid` one clock later. `done_count` equals the request count on a hit and is zero on a miss, and a miss raises no `fwd_valid`.
- R7: When several windows match, the lowest space index wins (memory, then I/O, then configuration, then special).
- R8: Reset and `reinit` set every window size to zero. A configuration write in the same cycle as `reinit` is dropped and raises no error.
- R9: A request in the same cycle as a configuration write is matched against the table as it stood before that write.
- R10: A DMA request whose `dma_space` is not 0 (memory) pulses `dma_err_space` one clock later and is not forwarded.
- R11: When the memory window has nonzero size, a memory DMA whose start address or end address (start + count) lies in [child base, child base + size], both bounds inclusive, pulses `dma_err_overlap` one clock later and is not forwarded.
- R12: Any other memory DMA pulses `dma_fwd_valid` one clock later. It carries the address, count and direction unchanged, with `dma_fwd_pspace` equal to the memory window's parent-space tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reinit | input | 1 | Clears the whole window table |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_space | input | 3 | Target space index of the write |
| cfg_parent_base | input | 32 | Window base on the parent side |
| cfg_child_base | input | 32 | Window base on the child side |
| cfg_size | input | 32 | Window size in bytes |
| cfg_parent_space | input | 2 | Parent-space tag used for DMA |
| cfg_err_dup | output | 1 | Duplicate window write pulse |
| cfg_err_space | output | 1 | Invalid space index pulse |
| req_valid | input | 1 | Outbound request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Parent-side address |
| req_count | input | 8 | Byte count |
| fwd_valid | output | 1 | Translated request pulse |
| fwd_write | output | 1 | Forwarded direction |
| fwd_addr | output | 32 | Child-side address |
| fwd_space | output | 2 | Child space index |
| fwd_count | output | 8 | Forwarded byte count |
| done_valid | output | 1 | Completion pulse for every request |
| done_count | output | 8 | Bytes transferred, zero on miss |
| dma_valid | input | 1 | DMA request strobe |
| dma_write | input | 1 | DMA direction |
| dma_space | input | 2 | DMA space index |
| dma_addr | input | 32 | DMA address |
| dma_count | input | 8 | DMA byte count |
| dma_fwd_valid | output | 1 | Accepted DMA pulse |
| dma_fwd_write | output | 1 | Forwarded DMA direction |
| dma_fwd_addr | output | 32 | Forwarded DMA address |
| dma_fwd_count | output | 8 | Forwarded DMA count |
| dma_fwd_pspace | output | 2 | Parent-space tag of the memory window |
| dma_err_space | output | 1 | Non-memory DMA pulse |
| dma_err_overlap | output | 1 | DMA overlapping own window pulse |

## Verification
A configuration write and an outbound request can land in the same cycle. The bench does this on purpose: it writes the empty configuration window while a request aimed inside that window is presented. It expects a miss on that request, then a hit on an identical request one cycle later. It also pairs `reinit` with a configuration write in one cycle and judges the result by the miss of a following request and by the absence of any error pulse.

// File: rtl/bwt_pkg.sv
package bwt_pkg;

    localparam int ADDR_W       = 32;
    localparam int CNT_W        = 8;
    localparam int PSPACE_W     = 2;
    localparam int N_SPACES     = 4;
    localparam int SPACE_IDX_W  = $clog2(N_SPACES);
    localparam int SPACE_CODE_W = SPACE_IDX_W + 1;
    localparam int WIDE_W       = ADDR_W + 1;

    typedef enum logic [SPACE_IDX_W-1:0] {
        SP_MEM     = 2'd0,
        SP_IO      = 2'd1,
        SP_CONFIG  = 2'd2,
        SP_SPECIAL = 2'd3
    } space_e;

    typedef struct packed {
        logic [ADDR_W-1:0]   pbase;
        logic [ADDR_W-1:0]   cbase;
        logic [ADDR_W-1:0]   size;
        logic [PSPACE_W-1:0] pspace;
    } win_t;

    function automatic logic [WIDE_W-1:0] widen(input logic [ADDR_W-1:0] a);
        return {1'b0, a};
    endfunction

    function automatic logic [WIDE_W-1:0] end_of(input logic [ADDR_W-1:0] a,
                                                 input logic [CNT_W-1:0]  n);
        return widen(a) + {{(WIDE_W-CNT_W){1'b0}}, n};
    endfunction

    // Full containment of [a, a+n) inside [base, base+size)
    function automatic logic contains(input logic [ADDR_W-1:0] a,
                                      input logic [CNT_W-1:0]  n,
                                      input logic [ADDR_W-1:0] base,
                                      input logic [ADDR_W-1:0] size);
        logic [WIDE_W-1:0] top;
        top = widen(base) + widen(size);
        return (size != '0) && (widen(a) >= widen(base)) && (end_of(a, n) <= top);
    endfunction

    // Point inside the closed range [base, base+size]
    function automatic logic in_closed(input logic [WIDE_W-1:0] p,
                                       input logic [ADDR_W-1:0] base,
                                       input logic [ADDR_W-1:0] size);
        return (p >= widen(base)) && (p <= widen(base) + widen(size));
    endfunction

endpackage

// File: rtl/bwt_window_table.sv
module bwt_window_table
    import bwt_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      reinit,
    input  logic                      cfg_valid,
    input  logic [SPACE_CODE_W-1:0]   cfg_space,
    input  win_t                      cfg_win,
    output win_t [N_SPACES-1:0]       table_q,
    output logic                      err_dup,
    output logic                      err_space
);

    localparam logic [SPACE_CODE_W-1:0] SPACE_LIMIT = SPACE_CODE_W'(N_SPACES);

    logic                   code_ok;
    logic [SPACE_IDX_W-1:0] idx;
    logic                   occupied;

    assign code_ok  = cfg_space < SPACE_LIMIT;
    assign idx      = cfg_space[SPACE_IDX_W-1:0];
    assign occupied = table_q[idx].size != '0;

    always_ff @(posedge clk) begin
        err_dup   <= 1'b0;
        err_space <= 1'b0;
        if (rst || reinit) begin
            table_q <= '0;
        end else if (cfg_valid) begin
            if (!code_ok)
                err_space <= 1'b1;
            else if (occupied)
                err_dup <= 1'b1;
            else
                table_q[idx] <= cfg_win;
        end
    end

    AST_DUP_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !reinit && code_ok && occupied) |=> (err_dup && table_q == $past(table_q))); // R2

    AST_BAD_SPACE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (cfg_valid && !reinit && !code_ok) |=> (err_space && table_q == $past(table_q))); // R3

    AST_REINIT_CLEARS: assert property (@(posedge clk) disable iff (rst)
        reinit |=> (table_q == '0 && !err_dup && !err_space)); // R8

endmodule

// File: rtl/bwt_outbound.sv
module bwt_outbound
    import bwt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  win_t [N_SPACES-1:0]     table_q,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CNT_W-1:0]        req_count,
    output logic                    fwd_valid,
    output logic                    fwd_write,
    output logic [ADDR_W-1:0]       fwd_addr,
    output logic [SPACE_IDX_W-1:0]  fwd_space,
    output logic [CNT_W-1:0]        fwd_count,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_count
);

    logic [N_SPACES-1:0]    hit;
    logic [SPACE_IDX_W-1:0] sel;
    logic                   any_hit;
    logic [ADDR_W-1:0]      xlated;

    for (genvar g = 0; g < N_SPACES; g++) begin : g_match
        assign hit[g] = contains(req_addr, req_count, table_q[g].pbase, table_q[g].size);
    end

    // Lowest index wins: scan downward so the last assignment is the lowest hit
    always_comb begin
        sel = '0;
        for (int i = N_SPACES - 1; i >= 0; i--) begin
            if (hit[i]) sel = SPACE_IDX_W'(i);
        end
    end

    assign any_hit = |hit;
    assign xlated  = req_addr - table_q[sel].pbase + table_q[sel].cbase;

    always_ff @(posedge clk) begin
        if (rst) begin
            fwd_valid  <= 1'b0;
            fwd_write  <= 1'b0;
            fwd_addr   <= '0;
            fwd_space  <= '0;
            fwd_count  <= '0;
            done_valid <= 1'b0;
            done_count <= '0;
        end else begin
            fwd_valid  <= req_valid && any_hit;
            done_valid <= req_valid;
            done_count <= (req_valid && any_hit) ? req_count : '0;
            if (req_valid && any_hit) begin
                fwd_write <= req_write;
                fwd_addr  <= xlated;
                fwd_space <= sel;
                fwd_count <= req_count;
            end
        end
    end

    AST_FWD_HAS_DONE: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> (done_valid && done_count == fwd_count)); // R6

    AST_FWD_FROM_REQ: assert property (@(posedge clk) disable iff (rst)
        fwd_valid |-> ($past(req_valid) && fwd_count == $past(req_count))); // R5

    AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (done_valid && !fwd_valid) |-> done_count == '0); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        (fwd_valid && !$past(req_valid, 2)) |=> !fwd_valid || $past(req_valid)); // R5

endmodule

// File: rtl/bwt_dma_check.sv
module bwt_dma_check
    import bwt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  win_t                    mem_win,
    input  logic                    dma_valid,
    input  logic                    dma_write,
    input  logic [SPACE_IDX_W-1:0]  dma_space,
    input  logic [ADDR_W-1:0]       dma_addr,
    input  logic [CNT_W-1:0]        dma_count,
    output logic                    dma_fwd_valid,
    output logic                    dma_fwd_write,
    output logic [ADDR_W-1:0]       dma_fwd_addr,
    output logic [CNT_W-1:0]        dma_fwd_count,
    output logic [PSPACE_W-1:0]     dma_fwd_pspace,
    output logic                    dma_err_space,
    output logic                    dma_err_overlap
);

    logic space_ok;
    logic overlap;

    assign space_ok = dma_space == SP_MEM;
    assign overlap  = (mem_win.size != '0) &&
                      (in_closed(widen(dma_addr), mem_win.cbase, mem_win.size) ||
                       in_closed(end_of(dma_addr, dma_count), mem_win.cbase, mem_win.size));

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_fwd_valid   <= 1'b0;
            dma_fwd_write   <= 1'b0;
            dma_fwd_addr    <= '0;
            dma_fwd_count   <= '0;
            dma_fwd_pspace  <= '0;
            dma_err_space   <= 1'b0;
            dma_err_overlap <= 1'b0;
        end else begin
            dma_err_space   <= dma_valid && !space_ok;
            dma_err_overlap <= dma_valid && space_ok && overlap;
            dma_fwd_valid   <= dma_valid && space_ok && !overlap;
            if (dma_valid && space_ok && !overlap) begin
                dma_fwd_write  <= dma_write;
                dma_fwd_addr   <= dma_addr;
                dma_fwd_count  <= dma_count;
                dma_fwd_pspace <= mem_win.pspace;
            end
        end
    end

    AST_DMA_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dma_fwd_valid, dma_err_space, dma_err_overlap})); // R12

    AST_DMA_MEM_ONLY: assert property (@(posedge clk) disable iff (rst)
        (dma_fwd_valid || dma_err_overlap) |-> $past(dma_space) == SP_MEM); // R10

    AST_DMA_ADDR_KEPT: assert property (@(posedge clk) disable iff (rst)
        dma_fwd_valid |-> (dma_fwd_addr == $past(dma_addr) && dma_fwd_count == $past(dma_count))); // R12

endmodule

// File: rtl/addr_window_bridge.sv
module addr_window_bridge
    import bwt_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    reinit,
    input  logic                    cfg_valid,
    input  logic [SPACE_CODE_W-1:0] cfg_space,
    input  logic [ADDR_W-1:0]       cfg_parent_base,
    input  logic [ADDR_W-1:0]       cfg_child_base,
    input  logic [ADDR_W-1:0]       cfg_size,
    input  logic [PSPACE_W-1:0]     cfg_parent_space,
    output logic                    cfg_err_dup,
    output logic                    cfg_err_space,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [ADDR_W-1:0]       req_addr,
    input  logic [CNT_W-1:0]        req_count,
    output logic                    fwd_valid,
    output logic                    fwd_write,
    output logic [ADDR_W-1:0]       fwd_addr,
    output logic [SPACE_IDX_W-1:0]  fwd_space,
    output logic [CNT_W-1:0]        fwd_count,
    output logic                    done_valid,
    output logic [CNT_W-1:0]        done_count,
    input  logic                    dma_valid,
    input  logic                    dma_write,
    input  logic [SPACE_IDX_W-1:0]  dma_space,
    input  logic [ADDR_W-1:0]       dma_addr,
    input  logic [CNT_W-1:0]        dma_count,
    output logic                    dma_fwd_valid,
    output logic                    dma_fwd_write,
    output logic [ADDR_W-1:0]       dma_fwd_addr,
    output logic [CNT_W-1:0]        dma_fwd_count,
    output logic [PSPACE_W-1:0]     dma_fwd_pspace,
    output logic                    dma_err_space,
    output logic                    dma_err_overlap
);

    win_t                cfg_win;
    win_t [N_SPACES-1:0] table_q;

    assign cfg_win = '{pbase:  cfg_parent_base,
                       cbase:  cfg_child_base,
                       size:   cfg_size,
                       pspace: cfg_parent_space};

    bwt_window_table u_table (
        .clk       (clk),
        .rst       (rst),
        .reinit    (reinit),
        .cfg_valid (cfg_valid),
        .cfg_space (cfg_space),
        .cfg_win   (cfg_win),
        .table_q   (table_q),
        .err_dup   (cfg_err_dup),
        .err_space (cfg_err_space)
    );

    bwt_outbound u_out (
        .clk        (clk),
        .rst        (rst),
        .table_q    (table_q),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_count  (req_count),
        .fwd_valid  (fwd_valid),
        .fwd_write  (fwd_write),
        .fwd_addr   (fwd_addr),
        .fwd_space  (fwd_space),
        .fwd_count  (fwd_count),
        .done_valid (done_valid),
        .done_count (done_count)
    );

    bwt_dma_check u_dma (
        .clk             (clk),
        .rst             (rst),
        .mem_win         (table_q[SP_MEM]),
        .dma_valid       (dma_valid),
        .dma_write       (dma_write),
        .dma_space       (dma_space),
        .dma_addr        (dma_addr),
        .dma_count       (dma_count),
        .dma_fwd_valid   (dma_fwd_valid),
        .dma_fwd_write   (dma_fwd_write),
        .dma_fwd_addr    (dma_fwd_addr),
        .dma_fwd_count   (dma_fwd_count),
        .dma_fwd_pspace  (dma_fwd_pspace),
        .dma_err_space   (dma_err_space),
        .dma_err_overlap (dma_err_overlap)
    );

    AST_REQ_BEFORE_CFG: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_valid && table_q == '0) |=> !fwd_valid); // R9

endmodule

// File: tb/tb_addr_window_bridge.sv
module tb_addr_window_bridge;

    logic        clk = 1'b0;
    logic        rst;
    logic        reinit;
    logic        cfg_valid;
    logic [2:0]  cfg_space;
    logic [31:0] cfg_parent_base, cfg_child_base, cfg_size;
    logic [1:0]  cfg_parent_space;
    logic        cfg_err_dup, cfg_err_space;
    logic        req_valid, req_write;
    logic [31:0] req_addr;
    logic [7:0]  req_count;
    logic        fwd_valid, fwd_write;
    logic [31:0] fwd_addr;
    logic [1:0]  fwd_space;
    logic [7:0]  fwd_count;
    logic        done_valid;
    logic [7:0]  done_count;
    logic        dma_valid, dma_write;
    logic [1:0]  dma_space;
    logic [31:0] dma_addr;
    logic [7:0]  dma_count;
    logic        dma_fwd_valid, dma_fwd_write;
    logic [31:0] dma_fwd_addr;
    logic [7:0]  dma_fwd_count;
    logic [1:0]  dma_fwd_pspace;
    logic        dma_err_space, dma_err_overlap;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] m_pb [4];
    logic [31:0] m_cb [4];
    logic [31:0] m_sz [4];
    logic [1:0]  m_ps [4];

    always #4 clk = ~clk;

    addr_window_bridge dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < 4; i++) begin
            m_pb[i] = '0; m_cb[i] = '0; m_sz[i] = '0; m_ps[i] = '0;
        end
    endtask

    // Returns matching index or -1, lowest index first
    function automatic int model_hit(input logic [31:0] a, input logic [7:0] n);
        for (int i = 0; i < 4; i++) begin
            if (m_sz[i] != 0 && {1'b0, a} >= {1'b0, m_pb[i]} &&
                ({1'b0, a} + 33'(n)) <= ({1'b0, m_pb[i]} + {1'b0, m_sz[i]}))
                return i;
        end
        return -1;
    endfunction

    task automatic idle_inputs();
        reinit = 0; cfg_valid = 0; cfg_space = 0; cfg_parent_base = 0; cfg_child_base = 0;
        cfg_size = 0; cfg_parent_space = 0; req_valid = 0; req_write = 0; req_addr = 0;
        req_count = 0; dma_valid = 0; dma_write = 0; dma_space = 0; dma_addr = 0; dma_count = 0;
    endtask

    task automatic drive_cfg(input logic [2:0] sp, input logic [31:0] pb, input logic [31:0] cb,
                             input logic [31:0] sz, input logic [1:0] ps);
        cfg_valid = 1; cfg_space = sp; cfg_parent_base = pb; cfg_child_base = cb;
        cfg_size = sz; cfg_parent_space = ps;
    endtask

    task automatic model_cfg(input logic [2:0] sp, input logic [31:0] pb, input logic [31:0] cb,
                             input logic [31:0] sz, input logic [1:0] ps);
        if (sp < 4 && m_sz[sp[1:0]] == 0) begin
            m_pb[sp[1:0]] = pb; m_cb[sp[1:0]] = cb; m_sz[sp[1:0]] = sz; m_ps[sp[1:0]] = ps;
        end
    endtask

    task automatic do_cfg(input logic [2:0] sp, input logic [31:0] pb, input logic [31:0] cb,
                          input logic [31:0] sz, input logic [1:0] ps);
        bit exp_sp, exp_dup;
        exp_sp  = sp >= 4;
        exp_dup = !exp_sp && m_sz[sp[1:0]] != 0;
        drive_cfg(sp, pb, cb, sz, ps);
        @(negedge clk);
        cfg_valid = 0;
        chk(cfg_err_space == exp_sp, "R3 cfg_err_space", 64'(cfg_err_space), 64'(exp_sp));
        chk(cfg_err_dup == exp_dup, "R2 cfg_err_dup", 64'(cfg_err_dup), 64'(exp_dup));
        model_cfg(sp, pb, cb, sz, ps);
        @(negedge clk);
        chk(!cfg_err_dup && !cfg_err_space, "R2 error pulse width", 64'({cfg_err_dup, cfg_err_space}), 64'd0);
    endtask

    task automatic judge_req(input logic [31:0] a, input logic [7:0] n, input bit w, input string tag);
        int h;
        logic [31:0] ea;
        h = model_hit(a, n);
        chk(done_valid, {tag, " R6 done_valid"}, 64'(done_valid), 64'd1);
        if (h < 0) begin
            chk(!fwd_valid, {tag, " R6 miss not forwarded"}, 64'(fwd_valid), 64'd0);
            chk(done_count == 0, {tag, " R6 miss count"}, 64'(done_count), 64'd0);
        end else begin
            ea = a - m_pb[h] + m_cb[h];
            chk(fwd_valid, {tag, " R4 hit"}, 64'(fwd_valid), 64'd1);
            chk(fwd_addr == ea, {tag, " R5 address"}, 64'(fwd_addr), 64'(ea));
            chk(fwd_space == 2'(h), {tag, " R7 space"}, 64'(fwd_space), 64'(h));
            chk(fwd_count == n && fwd_write == w, {tag, " R5 count/dir"},
                64'({fwd_write, fwd_count}), 64'({w, n}));
            chk(done_count == n, {tag, " R6 hit count"}, 64'(done_count), 64'(n));
        end
    endtask

    task automatic do_req(input logic [31:0] a, input logic [7:0] n, input bit w, input string tag);
        req_valid = 1; req_addr = a; req_count = n; req_write = w;
        @(negedge clk);
        req_valid = 0;
        judge_req(a, n, w, tag);
    endtask

    task automatic do_dma(input logic [1:0] sp, input logic [31:0] a, input logic [7:0] n, input bit w);
        bit e_sp, e_ov, e_fw;
        logic [32:0] s, e, lo, hi;
        s  = {1'b0, a};
        e  = s + 33'(n);
        lo = {1'b0, m_cb[0]};
        hi = lo + {1'b0, m_sz[0]};
        e_sp = sp != 0;
        e_ov = !e_sp && m_sz[0] != 0 && ((s >= lo && s <= hi) || (e >= lo && e <= hi));
        e_fw = !e_sp && !e_ov;
        dma_valid = 1; dma_space = sp; dma_addr = a; dma_count = n; dma_write = w;
        @(negedge clk);
        dma_valid = 0;
        chk(dma_err_space == e_sp, "R10 dma_err_space", 64'(dma_err_space), 64'(e_sp));
        chk(dma_err_overlap == e_ov, "R11 dma_err_overlap", 64'(dma_err_overlap), 64'(e_ov));
        chk(dma_fwd_valid == e_fw, "R12 dma_fwd_valid", 64'(dma_fwd_valid), 64'(e_fw));
        if (e_fw)
            chk(dma_fwd_addr == a && dma_fwd_count == n && dma_fwd_write == w && dma_fwd_pspace == m_ps[0],
                "R12 dma fields", 64'({dma_fwd_pspace, dma_fwd_write, dma_fwd_count, dma_fwd_addr}),
                64'({m_ps[0], w, n, a}));
    endtask

    task automatic sweep_window(input int i);
        logic [31:0] edges [2];
        edges[0] = m_pb[i];
        edges[1] = m_pb[i] + m_sz[i];
        for (int e = 0; e < 2; e++)
            for (int d = -5; d <= 5; d++)
                for (int n = 0; n <= 5; n++)
                    do_req(edges[e] + 32'(d), 8'(n), (n % 2) == 1, "sweep");
    endtask

    initial begin
        #(8 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        idle_inputs();
        model_clear();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);

        // R8: reset state, nothing mapped
        chk(!fwd_valid && !done_valid && !dma_fwd_valid && !cfg_err_dup && !cfg_err_space,
            "R8 outputs idle after reset", 64'({fwd_valid, done_valid, dma_fwd_valid}), 64'd0);
        do_req(32'h8000_0000, 8'd4, 0, "R8 empty table");

        // R9: config write and request in the same cycle
        drive_cfg(3'd0, 32'h8000_0000, 32'h0000_2000, 32'h1000, 2'd1);
        req_valid = 1; req_addr = 32'h8000_0010; req_count = 8'd4; req_write = 1;
        @(negedge clk);
        cfg_valid = 0; req_valid = 0;
        judge_req(32'h8000_0010, 8'd4, 1, "R9 same-cycle (old table)");
        model_cfg(3'd0, 32'h8000_0000, 32'h0000_2000, 32'h1000, 2'd1);
        do_req(32'h8000_0010, 8'd4, 1, "R9 next cycle (new table)");

        // R1: remaining windows
        do_cfg(3'd1, 32'hC000_0000, 32'h0000_0000, 32'h100, 2'd2);
        do_cfg(3'd3, 32'hD000_0000, 32'h0000_0400, 32'h40, 2'd3);

        // R4/R5/R6: edge sweeps
        sweep_window(0);
        sweep_window(1);
        sweep_window(3);

        // R2: duplicate leaves window unchanged
        do_cfg(3'd0, 32'h1234_0000, 32'h0, 32'h10, 2'd0);
        do_req(32'h8000_0100, 8'd2, 0, "R2 old window kept");

        // R3: invalid codes
        for (int c = 4; c < 8; c++) do_cfg(3'(c), 32'h8800_0000, 32'h9000, 32'h100, 2'd0);
        do_req(32'h8800_0000, 8'd1, 0, "R3 no change");

        // R7: config window overlapping memory window; memory wins
        do_cfg(3'd2, 32'h8000_0800, 32'h0005_0000, 32'h1000, 2'd0);
        do_req(32'h8000_0900, 8'd8, 0, "R7 memory wins");
        do_req(32'h8000_1000, 8'd8, 1, "R7 config past memory");
        do_req(32'h8000_0FFC, 8'd8, 0, "R7 straddle goes to config");

        // R10/R11/R12: DMA
        for (int s = 1; s < 4; s++) do_dma(2'(s), 32'h0000_5000, 8'd4, 0);
        for (int a = 32'h1FE8; a <= 32'h2008; a += 4)
            for (int n = 0; n <= 20; n += 5)
                do_dma(2'd0, 32'(a), 8'(n), (n % 2) == 1);
        for (int a = 32'h2FF8; a <= 32'h3008; a += 1)
            do_dma(2'd0, 32'(a), 8'd3, 1);

        // R8: reinit together with a config write
        reinit = 1;
        drive_cfg(3'd1, 32'hE000_0000, 32'h0, 32'h100, 2'd0);
        @(negedge clk);
        reinit = 0; cfg_valid = 0;
        chk(!cfg_err_dup && !cfg_err_space, "R8 no error on reinit cycle",
            64'({cfg_err_dup, cfg_err_space}), 64'd0);
        model_clear();
        do_req(32'hE000_0010, 8'd4, 0, "R8 dropped cfg");
        do_req(32'h8000_0010, 8'd4, 0, "R8 cleared memory");
        do_dma(2'd0, 32'h0000_2000, 8'd4, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule